// File: doc/BRIEF.md
# Subchannel Engine Binding Dispatcher

This block sits between a command-stream parser and a set of execution engines. Each incoming register write carries a method number, a 3-bit subchannel and a 32-bit value. Before any engine can receive writes, software binds a subchannel to an engine class by writing that class identifier to method 0 of the subchannel. The binding goes into an eight-entry table. Each entry holds a valid bit and a 16-bit class.

Method numbers below 0x100 belong to the dispatcher and are never passed on. For any higher method, the block looks up the class bound to the subchannel and decodes it to one of three engine write ports: 2D, 3D or compute. It then pulses that port's strobe for one cycle, with the method and value passed through unchanged. Writes that cannot be delivered set sticky error bits and produce no strobe.

A small state machine records the result of each write. Its states are `ST_IDLE` (no write), `ST_BIND` (a bind was accepted), `ST_FORWARD` (an engine strobe is issued) and `ST_REJECT` (the write raised an error). When `wr_valid` is high, the write decides the next state. When `wr_valid` is low, the machine returns to `ST_IDLE`. Every state lasts exactly one cycle.

Top module: `subch_dispatch`

## Requirements
- R1: After reset, every subchannel is unbound, `err_flags` is 0 and `eng_strobe` is 0. A later reset clears bindings made earlier.
- R2: A write to method 0 on an unbound subchannel stores the low 16 bits of `wr_value` as that subchannel's class. It produces no strobe and no error bit.
- R3: A write to method 0 on a subchannel that is already bound sets `err_flags[0]`. The table entry is left unchanged and no strobe is produced.
- R4: A write to any method from 1 to 0xFF sets `err_flags[1]` and produces no strobe.
- R5: A write to method 0x100 or above on a bound subchannel pulses exactly one strobe. Class 0x902D selects `eng_strobe[0]`, 0xB197 selects `eng_strobe[1]` and 0xB1C0 selects `eng_strobe[2]`. The pulse is high in the cycle after the write is sampled. `eng_method` and `eng_value` equal the written method and value during that pulse.
- R6: A forwarding write to an unbound subchannel sets `err_flags[2]` and produces no strobe.
- R7: A forwarding write to a subchannel bound to class 0xA140 or 0xB0B5 sets `err_flags[3]` and produces no strobe.
- R8: A class matching none of the five known values is accepted by a bind without error. A forwarding write that reaches it sets `err_flags[4]` and produces no strobe.
- R9: Error bits stay set until `err_clr` is sampled high, which clears them at that edge. An error raised by a write in the same cycle as `err_clr` is kept.
- R10: Writes may arrive on consecutive cycles. A bind takes effect for the very next write. A cycle without `wr_valid` yields no strobe, so each strobe lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write present this cycle |
| wr_method | input | 13 | Method number |
| wr_subch | input | 3 | Subchannel index |
| wr_value | input | 32 | Write data |
| err_clr | input | 1 | Clears the sticky error bits |
| eng_strobe | output | 3 | Per-engine write strobe: [0] 2D, [1] 3D, [2] compute |
| eng_method | output | 13 | Method presented to the engine |
| eng_value | output | 32 | Value presented to the engine |
| err_flags | output | 5 | Sticky errors: [0] rebind, [1] reserved method, [2] unbound, [3] unsupported engine, [4] unknown class |

## Verification
Two pairs of functions can fall in the same cycle, and both are tested.

The first pair is clearing the error bits and raising a new error. The bench samples `err_clr` high in the same cycle as a forward to an unbound subchannel. It then requires that only the new unbound bit is left set, and that this bit survives a following idle cycle.

The second pair is a table update followed at once by a lookup. The bench binds a subchannel and forwards to it on the next cycle, then checks that the correct strobe fires. It also rebinds a subchannel that is already bound and forwards to it, to show that the first binding still routes the write.

// File: rtl/subch_dispatch_pkg.sv
package subch_dispatch_pkg;

    localparam int unsigned CLASS_W = 16;
    localparam int unsigned N_PORTS = 3;
    localparam int unsigned ERR_W   = 5;

    localparam logic [CLASS_W-1:0] CLS_TWO_D   = 16'h902D;
    localparam logic [CLASS_W-1:0] CLS_THREE_D = 16'hB197;
    localparam logic [CLASS_W-1:0] CLS_COMPUTE = 16'hB1C0;
    localparam logic [CLASS_W-1:0] CLS_INLINE  = 16'hA140;
    localparam logic [CLASS_W-1:0] CLS_COPY    = 16'hB0B5;

    localparam int unsigned E_REBIND  = 0;
    localparam int unsigned E_RESERVE = 1;
    localparam int unsigned E_UNBOUND = 2;
    localparam int unsigned E_UNSUPP  = 3;
    localparam int unsigned E_UNKNOWN = 4;

    typedef enum logic [2:0] {
        KIND_TWO_D,
        KIND_THREE_D,
        KIND_COMPUTE,
        KIND_INLINE,
        KIND_COPY,
        KIND_UNKNOWN
    } eng_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BIND,
        ST_FORWARD,
        ST_REJECT
    } disp_state_e;

endpackage

// File: rtl/subch_bind_table.sv
module subch_bind_table #(
    parameter int unsigned NSUB = 8,
    parameter int unsigned CW   = 16,
    localparam int unsigned SW  = $clog2(NSUB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_idx,
    input  logic [CW-1:0] wr_cls,
    input  logic [SW-1:0] rd_idx,
    output logic          rd_valid,
    output logic [CW-1:0] rd_cls
);

    logic [NSUB-1:0] valid_q;
    logic [CW-1:0]   cls_q [NSUB];

    for (genvar g = 0; g < NSUB; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                cls_q[g]   <= '0;
            end else if (wr_en && (wr_idx == SW'(g))) begin
                valid_q[g] <= 1'b1;
                cls_q[g]   <= wr_cls;
            end
        end
    end

    always_comb begin
        rd_valid = valid_q[rd_idx];
        rd_cls   = cls_q[rd_idx];
    end

endmodule

// File: rtl/subch_class_decode.sv
module subch_class_decode
    import subch_dispatch_pkg::*;
(
    input  logic [CLASS_W-1:0] cls,
    output eng_kind_e          kind
);

    always_comb begin
        case (cls)
            CLS_TWO_D:   kind = KIND_TWO_D;
            CLS_THREE_D: kind = KIND_THREE_D;
            CLS_COMPUTE: kind = KIND_COMPUTE;
            CLS_INLINE:  kind = KIND_INLINE;
            CLS_COPY:    kind = KIND_COPY;
            default:     kind = KIND_UNKNOWN;
        endcase
    end

endmodule

// File: rtl/subch_dispatch.sv
module subch_dispatch
    import subch_dispatch_pkg::*;
#(
    parameter int unsigned MW        = 13,
    parameter int unsigned SUBW      = 3,
    parameter int unsigned DW        = 32,
    parameter int unsigned RSV_LIMIT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [MW-1:0]      wr_method,
    input  logic [SUBW-1:0]    wr_subch,
    input  logic [DW-1:0]      wr_value,
    input  logic               err_clr,
    output logic [N_PORTS-1:0] eng_strobe,
    output logic [MW-1:0]      eng_method,
    output logic [DW-1:0]      eng_value,
    output logic [ERR_W-1:0]   err_flags
);

    localparam int unsigned NSUB   = 1 << SUBW;
    localparam logic [MW-1:0] RSV_TOP = MW'(RSV_LIMIT);

    disp_state_e        st_q, st_d;
    logic [N_PORTS-1:0] tgt_q, tgt_d;
    logic [MW-1:0]      meth_q;
    logic [DW-1:0]      val_q;
    logic [ERR_W-1:0]   err_q, err_set;

    logic               is_bind, is_rsv;
    logic               ent_valid;
    logic [CLASS_W-1:0] ent_cls;
    eng_kind_e          ent_kind;
    logic               tbl_we;

    assign is_bind = (wr_method == '0);
    assign is_rsv  = !is_bind && (wr_method < RSV_TOP);
    assign tbl_we  = wr_valid && is_bind && !ent_valid;

    subch_bind_table #(
        .NSUB (NSUB),
        .CW   (CLASS_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (wr_subch),
        .wr_cls   (wr_value[CLASS_W-1:0]),
        .rd_idx   (wr_subch),
        .rd_valid (ent_valid),
        .rd_cls   (ent_cls)
    );

    subch_class_decode u_decode (
        .cls  (ent_cls),
        .kind (ent_kind)
    );

    // Next state, target port and error causes for the write in flight.
    always_comb begin
        st_d    = ST_IDLE;
        tgt_d   = '0;
        err_set = '0;
        if (wr_valid) begin
            if (is_bind) begin
                if (ent_valid) begin
                    st_d              = ST_REJECT;
                    err_set[E_REBIND] = 1'b1;
                end else begin
                    st_d = ST_BIND;
                end
            end else if (is_rsv) begin
                st_d               = ST_REJECT;
                err_set[E_RESERVE] = 1'b1;
            end else if (!ent_valid) begin
                st_d               = ST_REJECT;
                err_set[E_UNBOUND] = 1'b1;
            end else begin
                unique case (ent_kind)
                    KIND_TWO_D: begin
                        st_d     = ST_FORWARD;
                        tgt_d[0] = 1'b1;
                    end
                    KIND_THREE_D: begin
                        st_d     = ST_FORWARD;
                        tgt_d[1] = 1'b1;
                    end
                    KIND_COMPUTE: begin
                        st_d     = ST_FORWARD;
                        tgt_d[2] = 1'b1;
                    end
                    KIND_INLINE, KIND_COPY: begin
                        st_d              = ST_REJECT;
                        err_set[E_UNSUPP] = 1'b1;
                    end
                    default: begin
                        st_d               = ST_REJECT;
                        err_set[E_UNKNOWN] = 1'b1;
                    end
                endcase
            end
        end
    end

    // State register together with the payload it qualifies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            tgt_q  <= '0;
            meth_q <= '0;
            val_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_d == ST_FORWARD) begin
                tgt_q  <= tgt_d;
                meth_q <= wr_method;
                val_q  <= wr_value;
            end
        end
    end

    // Sticky error bits: a clear and a new error in one cycle keep the new error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= (err_clr ? '0 : err_q) | err_set;
        end
    end

    // Outputs derived from the registered state.
    always_comb begin
        eng_strobe = '0;
        unique case (st_q)
            ST_FORWARD:                  eng_strobe = tgt_q;
            ST_IDLE, ST_BIND, ST_REJECT: eng_strobe = '0;
            default:                     eng_strobe = '0;
        endcase
        eng_method = meth_q;
        eng_value  = val_q;
        err_flags  = err_q;
    end

endmodule

// File: rtl/subch_dispatch_chk.sv
module subch_dispatch_chk #(
    parameter int unsigned MW        = 13,
    parameter int unsigned SUBW      = 3,
    parameter int unsigned DW        = 32,
    parameter int unsigned RSV_LIMIT = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_valid,
    input logic [MW-1:0]   wr_method,
    input logic [SUBW-1:0] wr_subch,
    input logic [DW-1:0]   wr_value,
    input logic            err_clr,
    input logic [2:0]      eng_strobe,
    input logic [MW-1:0]   eng_method,
    input logic [DW-1:0]   eng_value,
    input logic [4:0]      err_flags
);

    localparam logic [MW-1:0] RSV_TOP = MW'(RSV_LIMIT);

    assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_strobe));

    assert_fwd_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_method >= RSV_TOP) |=>
        (eng_strobe == 3'b000) ||
        (eng_method == $past(wr_method) && eng_value == $past(wr_value)));

    assert_bind_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_method == '0) |=> (eng_strobe == 3'b000));

    assert_reserved_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_method != '0 && wr_method < RSV_TOP) |=>
        (eng_strobe == 3'b000 && err_flags[1]));

    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> (eng_strobe == 3'b000));

    assert_strobe_method_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_strobe != 3'b000) |-> (eng_method >= RSV_TOP));

endmodule

bind subch_dispatch subch_dispatch_chk #(
    .MW        (MW),
    .SUBW      (SUBW),
    .DW        (DW),
    .RSV_LIMIT (RSV_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_method  (wr_method),
    .wr_subch   (wr_subch),
    .wr_value   (wr_value),
    .err_clr    (err_clr),
    .eng_strobe (eng_strobe),
    .eng_method (eng_method),
    .eng_value  (eng_value),
    .err_flags  (err_flags)
);

// File: tb/test_subch_dispatch.sv
`timescale 1ns/1ps
module test_subch_dispatch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_method = '0;
    logic [2:0]  wr_subch = '0;
    logic [31:0] wr_value = '0;
    logic        err_clr = 1'b0;
    logic [2:0]  eng_strobe;
    logic [12:0] eng_method;
    logic [31:0] eng_value;
    logic [4:0]  err_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    subch_dispatch i_subch_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_method(wr_method),
        .wr_subch(wr_subch), .wr_value(wr_value), .err_clr(err_clr),
        .eng_strobe(eng_strobe), .eng_method(eng_method), .eng_value(eng_value),
        .err_flags(err_flags)
    );

    typedef struct packed {
        logic        vld;
        logic [12:0] meth;
        logic [2:0]  sub;
        logic [31:0] val;
        logic        clr;
        logic [2:0]  x_strobe;
        logic [4:0]  x_flags;
        logic [3:0]  req;
    } vec_t;

    function automatic vec_t mk(logic v, logic [12:0] m, logic [2:0] s, logic [31:0] d,
                                logic c, logic [2:0] xs, logic [4:0] xf, logic [3:0] r);
        return '{vld:v, meth:m, sub:s, val:d, clr:c, x_strobe:xs, x_flags:xf, req:r};
    endfunction

    function automatic string rname(logic [3:0] r);
        case (r)
            4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
            4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
            4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
            default: return "R10";
        endcase
    endfunction

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        mk(1, 13'h000, 3'd0, 32'h0000_902D, 0, 3'b000, 5'b00000, 2),  // R2 bind 2D
        mk(1, 13'h000, 3'd1, 32'h0000_B197, 0, 3'b000, 5'b00000, 2),
        mk(1, 13'h000, 3'd2, 32'hFFFF_B1C0, 0, 3'b000, 5'b00000, 2),  // upper bits dropped
        mk(1, 13'h000, 3'd3, 32'h0000_A140, 0, 3'b000, 5'b00000, 2),
        mk(1, 13'h000, 3'd4, 32'h1234_B0B5, 0, 3'b000, 5'b00000, 2),
        mk(1, 13'h000, 3'd5, 32'h0000_7777, 0, 3'b000, 5'b00000, 8),  // R8 unknown bind ok
        mk(1, 13'h100, 3'd0, 32'hDEAD_BEEF, 0, 3'b001, 5'b00000, 5),  // R5 boundary 0x100
        mk(1, 13'h1FFF,3'd1, 32'h0000_0001, 0, 3'b010, 5'b00000, 5),
        mk(1, 13'h0ABC,3'd2, 32'hCAFE_F00D, 0, 3'b100, 5'b00000, 5),
        mk(1, 13'h200, 3'd3, 32'h0000_0005, 0, 3'b000, 5'b01000, 7),  // R7 inline
        mk(1, 13'h200, 3'd4, 32'h0000_0006, 0, 3'b000, 5'b01000, 7),  // R7 copy
        mk(1, 13'h300, 3'd5, 32'h0000_0007, 0, 3'b000, 5'b11000, 8),  // R8 unknown use
        mk(1, 13'h300, 3'd6, 32'h0000_0008, 0, 3'b000, 5'b11100, 6),  // R6 unbound
        mk(1, 13'h005, 3'd0, 32'h0000_0009, 0, 3'b000, 5'b11110, 4),  // R4
        mk(1, 13'h0FF, 3'd1, 32'h0000_000A, 0, 3'b000, 5'b11110, 4),  // R4 top of range
        mk(1, 13'h000, 3'd0, 32'h0000_B197, 0, 3'b000, 5'b11111, 3),  // R3 rebind
        mk(1, 13'h104, 3'd0, 32'h5555_AAAA, 0, 3'b001, 5'b11111, 3),  // R3 table unchanged
        mk(0, 13'h000, 3'd0, 32'h0000_0000, 1, 3'b000, 5'b00000, 9),  // R9 clear
        mk(1, 13'h300, 3'd6, 32'h0000_0000, 1, 3'b000, 5'b00100, 9),  // R9 clear+error
        mk(0, 13'h000, 3'd0, 32'h0000_0000, 0, 3'b000, 5'b00100, 9),  // R9 held
        mk(0, 13'h000, 3'd0, 32'h0000_0000, 1, 3'b000, 5'b00000, 9),
        mk(1, 13'h000, 3'd6, 32'h0000_B1C0, 0, 3'b000, 5'b00000, 10), // R10 bind ...
        mk(1, 13'h180, 3'd6, 32'h0BAD_CAFE, 0, 3'b100, 5'b00000, 10), // ... used next cycle
        mk(0, 13'h000, 3'd0, 32'h0000_0000, 0, 3'b000, 5'b00000, 10)  // R10 one-cycle pulse
    };

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [12:0] m, logic [2:0] s, logic [31:0] d, logic c);
        @(negedge clk);
        wr_valid = v; wr_method = m; wr_subch = s; wr_value = d; err_clr = c;
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1", "strobe after reset", 32'(eng_strobe), 0);
        check("R1", "flags after reset", 32'(err_flags), 0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].vld, VECS[i].meth, VECS[i].sub, VECS[i].val, VECS[i].clr);
            check(rname(VECS[i].req), $sformatf("vec%0d strobe", i),
                  32'(eng_strobe), 32'(VECS[i].x_strobe));
            check(rname(VECS[i].req), $sformatf("vec%0d flags", i),
                  32'(err_flags), 32'(VECS[i].x_flags));
            if (VECS[i].x_strobe != 3'b000) begin
                check(rname(VECS[i].req), $sformatf("vec%0d method", i),
                      32'(eng_method), 32'(VECS[i].meth));
                check(rname(VECS[i].req), $sformatf("vec%0d value", i),
                      eng_value, VECS[i].val);
            end
        end

        // R1: a mid-run reset wipes the bindings made above.
        @(negedge clk);
        rst_n = 1'b0;
        wr_valid = 1'b0; err_clr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1, 13'h100, 3'd0, 32'h1, 0);
        check("R1", "bound entry cleared by reset", 32'(eng_strobe), 0);
        check("R1", "unbound flag after reset", 32'(err_flags), 32'b00100);

        // R10: back-to-back forwards on different ports, then quiet.
        drive(1, 13'h000, 3'd7, 32'h902D, 1);
        drive(1, 13'h000, 3'd3, 32'hB197, 0);
        drive(1, 13'h400, 3'd7, 32'h11, 0);
        check("R10", "first of pair", 32'(eng_strobe), 32'b001);
        drive(1, 13'h401, 3'd3, 32'h22, 0);
        check("R10", "second of pair", 32'(eng_strobe), 32'b010);
        check("R10", "second value", eng_value, 32'h22);
        drive(0, 13'h0, 3'd0, 32'h0, 0);
        check("R10", "pulse ends", 32'(eng_strobe), 0);
        check("R2", "binds raised no error", 32'(err_flags), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule